// File: doc/BRIEF.md
# FIFO Slice Output Stage with Parallel and Serial Unload

This block is the exit stage of a narrow FIFO slice. It sits below a fall-through stack and takes the word at the bottom of the stack with a one-cycle pop pulse. It holds that word and hands it out in one of two ways. The first is a parallel word on a bus that can be driven or released. The second is a bit stream on a serial line that the block enables by itself. A ready flag reports when the register holds a word that the consumer has not yet taken.

Every input is sampled on one system clock. This includes the serial shift clock, whose falling edges are detected. Bus release is modelled with drive-enable outputs next to each data output. Several slices can work side by side as one wide FIFO. In that case one slice acts as lead and the others are followers. A follower holds its ready flag low until an enable arrives from the next slice up the chain. This keeps the flags of an array in step.

Top module: `fifo_out_stage`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `word_rdy`, `ser_drv` and `stk_pop` are all low.
- R2: When `par_req` is high, `stk_valid` is high and the register is empty, `stk_pop` is high in that same cycle. On the next edge the word from `stk_data` is captured on `par_q`. On a lead slice (`lead`=1), `word_rdy` goes high after that edge.
- R3: In parallel mode a held word is released at the first edge that samples `par_req` low: `word_rdy` falls, and `par_q` keeps the old word until the next load.
- R4: `par_req` is level-sensitive. A word that becomes valid while `par_req` is still high is loaded. If `par_req` pulses high while the stack is empty, nothing is loaded, no pop is issued and `word_rdy` stays low.
- R5: While the register holds a word, `stk_pop` stays low whatever `par_req`, `ser_req_n` and `stk_valid` do, so each stack word is popped and loaded exactly once.
- R6: A load in which `ser_req_n` is low selects serial mode. After the load edge `ser_drv` is high and `ser_q` carries bit 0 of the word.
- R7: In serial mode each sampled falling edge of `sclk` advances `ser_q` to the next higher bit (bit 0 first, bit 3 last). The edge that detects the fourth fall empties the register, drops `word_rdy` and drops `ser_drv`.
- R8: A falling edge of `sclk` changes nothing while the register is empty or holds a parallel-mode word: `word_rdy`, `ser_drv` and `par_q` keep their values.
- R9: `par_drv` follows the `bus_en` input in the same cycle.
- R10: On a follower slice (`lead`=0), `word_rdy` stays low after a load until an edge samples `grant` high. From then on it stays high, even if `grant` falls, until the word is released. The next word again waits for `grant`.
- R11: With `par_req` high and `ser_req_n` low, a pending stack word is loaded on the edge after the fourth serial fall. This gives back-to-back serial words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stk_data | input | 4 | Word at the bottom of the stack |
| stk_valid | input | 1 | Bottom stack word is present |
| stk_pop | output | 1 | One-cycle pop of the bottom stack word |
| par_req | input | 1 | Level-sensitive transfer request; high arms a load, low releases a parallel word |
| ser_req_n | input | 1 | Active-low serial request; low at load time selects serial unload |
| sclk | input | 1 | Serial shift clock, sampled; falling edges shift |
| lead | input | 1 | 1 = lead slice, 0 = follower |
| grant | input | 1 | Follower enable from the slice above |
| bus_en | input | 1 | Parallel bus drive enable request |
| par_q | output | 4 | Parallel data word |
| par_drv | output | 1 | Parallel bus is driven |
| ser_q | output | 1 | Serial data bit |
| ser_drv | output | 1 | Serial line is driven |
| word_rdy | output | 1 | Register holds an untaken word |

## Verification
The bench goes after the double-load hazard. It keeps `par_req` high across a loaded word while a second word waits in the stack. A design without the full-register guard would pop the second word and overwrite the first, which shows up as an extra pop and a wrong `par_q`. It checks the fourth serial fall exactly. An off-by-one counter would either drop `word_rdy` one bit early or leave `ser_drv` on for a fifth bit. It toggles `sclk` while the register is empty and while it holds a parallel word, where a careless shifter would corrupt data or underflow its count. It also drives a follower with `grant` both low and high across two loads, which catches a ready flag that rises without the chain enable or a latch that is never cleared between words.

// File: rtl/oreg_pkg.sv
// Shared types for the FIFO output stage.
// Assumes: one system clock domain; all users import this package.
package oreg_pkg;
    typedef enum logic [0:0] {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } unload_mode_t;
endpackage

// File: rtl/oreg_seq.sv
// Load and unload sequencer: decides when a stack word is taken, which
// unload mode it uses and how many serial bits remain.
// Assumes: sclk is a slow level sampled on clk; stk_valid is stable
// within a cycle.
module oreg_seq
    import oreg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic par_req,
    input  logic ser_req_n,
    input  logic sclk,
    input  logic stk_valid,
    output logic load,
    output logic shift,
    output logic full,
    output logic ser_mode
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] bits_left;
    unload_mode_t  mode;
    logic          sclk_q;
    logic          sclk_fall;

    // Purpose: keep the previous sclk sample for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Purpose: decode the request, edge and occupancy conditions.
    always_comb begin
        sclk_fall = sclk_q & ~sclk;
        full      = (bits_left != '0);
        ser_mode  = (mode == MODE_SER);
        load      = par_req & stk_valid & ~full;
        shift     = sclk_fall & full & ser_mode;
    end

    // Purpose: track occupancy, unload mode and remaining serial bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_left <= '0;
            mode      <= MODE_PAR;
        end else if (load) begin
            bits_left <= CW'(W);
            mode      <= ser_req_n ? MODE_PAR : MODE_SER;
        end else if (shift) begin
            bits_left <= bits_left - CW'(1);
        end else if (full && !ser_mode && !par_req) begin
            bits_left <= '0;
        end
    end

    // R5: a load is always followed by a full register with all bits present.
    a_r5_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bits_left == CW'(W)));

    // R7: every serial shift consumes exactly one bit.
    a_r7_one_bit_per_fall: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (bits_left == $past(bits_left) - CW'(1)));

    // R3: a parallel word is released when the request level is low.
    a_r3_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ser_mode && !par_req) |=> !full);

    // R8: a falling sclk without a serial word leaves occupancy alone.
    a_r8_idle_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !ser_mode && par_req && full) |=> full);
endmodule

// File: rtl/oreg_data.sv
// Data holding for the output stage: a parallel word register that keeps
// its value until the next load, and a separate shift register whose
// bit 0 feeds the serial line.
// Assumes: load and shift are never high together (sequencer guarantees).
module oreg_data #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] par_word,
    output logic         ser_bit
);
    logic [W-1:0] hold_q;
    logic [W-1:0] shreg_q;

    // Purpose: capture the parallel word on each load only.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= din;
    end

    // Purpose: load the shift register, then move it down one bit per shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     shreg_q <= '0;
        else if (load)  shreg_q <= din;
        else if (shift) shreg_q <= {1'b0, shreg_q[W-1:1]};
    end

    // Purpose: drive the outputs from the registers.
    always_comb begin
        par_word = hold_q;
        ser_bit  = shreg_q[0];
    end

    // R3: the parallel word only changes on a load.
    a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold_q));

    // R7: a shift moves the next higher bit into the serial position.
    a_r7_next_bit: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (shreg_q[0] == $past(shreg_q[1])));
endmodule

// File: rtl/oreg_lock.sv
// Interlock for the ready flag. A lead slice reports a held word at once.
// A follower latches the chain enable while it holds a word and reports
// ready only after that.
// Assumes: grant comes from the slice above in the chain.
module oreg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic lead,
    input  logic grant,
    output logic ready
);
    logic granted_q;

    // Purpose: remember a chain enable seen during the current word.
    always_ff @(posedge clk) begin
        if (!rst_n)     granted_q <= 1'b0;
        else if (!full) granted_q <= 1'b0;
        else            granted_q <= granted_q | grant;
    end

    // Purpose: form the ready flag from occupancy and the interlock.
    always_comb begin
        ready = full & (lead | granted_q);
    end

    // R10: a follower that has seen no grant keeps ready low.
    a_r10_follower_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (!lead && !grant && !ready) ##1 !lead |-> !ready);
endmodule

// File: rtl/fifo_out_stage.sv
// FIFO slice output stage. It pops a word from the bottom of the stack
// and presents it either as a parallel word or as a serial bit stream,
// with a ready flag that obeys the lead/follower interlock.
// Assumes: every input is synchronous to clk; bus release is modelled
// with the *_drv outputs.
module fifo_out_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stk_data,
    input  logic         stk_valid,
    output logic         stk_pop,
    input  logic         par_req,
    input  logic         ser_req_n,
    input  logic         sclk,
    input  logic         lead,
    input  logic         grant,
    input  logic         bus_en,
    output logic [W-1:0] par_q,
    output logic         par_drv,
    output logic         ser_q,
    output logic         ser_drv,
    output logic         word_rdy
);
    logic load;
    logic shift;
    logic full;
    logic ser_mode;

    oreg_seq #(.W(W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_req   (par_req),
        .ser_req_n (ser_req_n),
        .sclk      (sclk),
        .stk_valid (stk_valid),
        .load      (load),
        .shift     (shift),
        .full      (full),
        .ser_mode  (ser_mode)
    );

    oreg_data #(.W(W)) data_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .din      (stk_data),
        .par_word (par_q),
        .ser_bit  (ser_q)
    );

    oreg_lock lock_i (
        .clk   (clk),
        .rst_n (rst_n),
        .full  (full),
        .lead  (lead),
        .grant (grant),
        .ready (word_rdy)
    );

    // Purpose: form the pop strobe and the drive enables.
    always_comb begin
        stk_pop = load;
        ser_drv = full & ser_mode;
        par_drv = bus_en;
    end

    // R2: on a lead slice a pop is followed by a ready flag.
    a_r2_lead_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_pop && lead) ##1 lead |-> word_rdy);

    // R5: no pop while a word is still being held.
    a_r5_no_pop_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
        word_rdy |-> !stk_pop);

    // R6: the serial line is driven only while a word is held.
    a_r6_drive_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_drv && lead) |-> word_rdy);
endmodule

// File: tb/fifo_out_stage_tb_top.sv
// Scoreboard bench for fifo_out_stage: push_word models the stack and
// queues the expected word; the check tasks pop the queue and compare.
module fifo_out_stage_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] stk_data;
    logic         stk_valid;
    logic         stk_pop;
    logic         par_req = 1'b0;
    logic         ser_req_n = 1'b1;
    logic         sclk = 1'b0;
    logic         lead = 1'b1;
    logic         grant = 1'b0;
    logic         bus_en = 1'b0;
    logic [W-1:0] par_q;
    logic         par_drv;
    logic         ser_q;
    logic         ser_drv;
    logic         word_rdy;

    logic [W-1:0] mem [16];
    int           wr_idx = 0;
    int           rd_idx = 0;
    int           pops = 0;
    int           vecs = 0;
    int           errs = 0;
    bit           done = 1'b0;
    logic [W-1:0] exp_q [$];

    always #4 clk = ~clk;  // 125 MHz

    fifo_out_stage #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .stk_data(stk_data), .stk_valid(stk_valid),
        .stk_pop(stk_pop), .par_req(par_req), .ser_req_n(ser_req_n),
        .sclk(sclk), .lead(lead), .grant(grant), .bus_en(bus_en),
        .par_q(par_q), .par_drv(par_drv), .ser_q(ser_q), .ser_drv(ser_drv),
        .word_rdy(word_rdy)
    );

    // Stack model: bottom word and its valid flag.
    assign stk_valid = (rd_idx < wr_idx);
    assign stk_data  = mem[rd_idx % 16];

    always @(posedge clk) begin
        if (rst_n && stk_pop) begin
            rd_idx <= rd_idx + 1;
            pops   <= pops + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push_word(input logic [W-1:0] w);
        mem[wr_idx % 16] = w;
        wr_idx++;
        exp_q.push_back(w);
    endtask

    // Monitor step: compare the parallel word against the scoreboard head.
    task automatic check_par(input string tag);
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(tag, par_q, e);
    endtask

    // Monitor step: shift out one serial word and compare each bit.
    task automatic check_ser(input string tag);
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk({tag, " bit0"}, ser_q, e[0]);
        chk({tag, " drv"}, ser_drv, 1);
        for (int i = 0; i < W; i++) begin
            sclk = 1'b1; tick();
            sclk = 1'b0; tick();
            if (i < W - 1) begin
                chk({tag, " R7 next bit"}, ser_q, e[i+1]);
                chk({tag, " R7 rdy mid"}, word_rdy, 1);
            end else begin
                chk({tag, " R7 rdy after last"}, word_rdy, 0);
                chk({tag, " R7 drv after last"}, ser_drv, 0);
            end
        end
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 rdy", word_rdy, 0);
        chk("R1 ser_drv", ser_drv, 0);
        chk("R1 pop", stk_pop, 0);
        rst_n = 1'b1;
        tick();

        // R4: request pulse with an empty stack
        par_req = 1'b1; tick(); tick(); par_req = 1'b0; tick();
        chk("R4 no data rdy", word_rdy, 0);
        chk("R4 no pop", pops, 0);

        // R2: parallel load
        push_word(4'h9); par_req = 1'b1; #1;
        chk("R2 pop same cycle", stk_pop, 1);
        tick();
        chk("R2 rdy", word_rdy, 1);
        check_par("R2 word");
        // R5: second word waits while request stays high
        push_word(4'h6); #1;
        chk("R5 no pop while full", stk_pop, 0);
        tick(); tick();
        chk("R5 single pop", pops, 1);
        chk("R5 word kept", par_q, 9);
        // R3: release
        par_req = 1'b0; tick();
        chk("R3 rdy low", word_rdy, 0);
        chk("R3 word kept", par_q, 9);
        par_req = 1'b1; tick();
        chk("R2 second rdy", word_rdy, 1);
        check_par("R2 second word");
        par_req = 1'b0; tick();

        // R4: data arrives while the request is high
        par_req = 1'b1; tick(); tick();
        chk("R4 waiting rdy", word_rdy, 0);
        push_word(4'hC); tick();
        chk("R4 late data rdy", word_rdy, 1);
        check_par("R4 late word");
        // R8: sclk falls during a parallel word
        sclk = 1'b1; tick(); sclk = 1'b0; tick();
        chk("R8 par rdy", word_rdy, 1);
        chk("R8 par word", par_q, 12);
        chk("R8 par ser_drv", ser_drv, 0);
        par_req = 1'b0; tick();

        // R9: bus drive
        bus_en = 1'b1; #1; chk("R9 drv on", par_drv, 1);
        bus_en = 1'b0; #1; chk("R9 drv off", par_drv, 0);

        // R6/R7: serial word
        ser_req_n = 1'b0; par_req = 1'b1; push_word(4'hB); tick();
        chk("R6 rdy", word_rdy, 1);
        check_ser("R6 serial");
        // R8: sclk falls while empty
        sclk = 1'b1; tick(); sclk = 1'b0; tick();
        chk("R8 empty rdy", word_rdy, 0);
        chk("R8 empty drv", ser_drv, 0);

        // R11: back-to-back serial words
        push_word(4'h5); push_word(4'hE); tick();
        check_ser("R11 first");
        tick();
        chk("R11 reload rdy", word_rdy, 1);
        check_ser("R11 second");
        par_req = 1'b0; ser_req_n = 1'b1; tick();

        // R10: follower interlock
        lead = 1'b0;
        push_word(4'h3); par_req = 1'b1; tick();
        chk("R10 no grant", word_rdy, 0);
        check_par("R10 word");
        tick();
        chk("R10 still waits", word_rdy, 0);
        grant = 1'b1; tick();
        chk("R10 granted", word_rdy, 1);
        grant = 1'b0; tick();
        chk("R10 latched", word_rdy, 1);
        par_req = 1'b0; tick();
        chk("R10 release", word_rdy, 0);
        push_word(4'hA); par_req = 1'b1; tick();
        chk("R10 next waits", word_rdy, 0);
        check_par("R10 next word");
        grant = 1'b1; tick();
        chk("R10 next granted", word_rdy, 1);
        grant = 1'b0; par_req = 1'b0; tick();

        chk("R5 total pops", pops, 8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule